// File: doc/BRIEF.md
# Halfword Instruction Length Assembler

This block sits between an instruction fetch unit and a decoder. Fetch hands it one halfword per beat over a valid/ready handshake. Each halfword is taken as a value: the low-addressed byte of the little-endian pair is bits [7:0]. Every instruction is either a single 16-bit halfword or a 32-bit instruction made of two consecutive halfwords. The block looks at bits [15:11] of the halfword that begins an instruction. If they are 0b11101, 0b11110 or 0b11111, that halfword is the leading half of a 32-bit instruction. Any other value there marks a complete 16-bit instruction.

When a leading half arrives, the block keeps it and waits, however long upstream stalls, for the next halfword. It then emits the two halves as one 32-bit word. Each emitted instruction carries a width flag and the address of its first halfword. The block counts addresses itself, starting from a reset value and moving forward two bytes for every halfword it accepts. A flush input drops any kept leading half and any undelivered output, and loads a new fetch address. Length classification is the only decoding it does.

Top module: `insn_pairer`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the first instruction emitted carries address RESET_ADDR.
- R2: A starting halfword whose bits [15:11] are not 0b11101, 0b11110 or 0b11111 is emitted one cycle after acceptance with out_wide=0, out_insn[15:0] equal to the halfword and out_insn[31:16]=0.
- R3: A starting halfword whose bits [15:11] are 0b11101, 0b11110 or 0b11111 produces no output in the cycle after it is accepted.
- R4: A 32-bit instruction is emitted with out_wide=1, the leading halfword in out_insn[31:16] and the second halfword in out_insn[15:0].
- R5: out_addr is the address of the instruction's first halfword, and the internal address advances by 2 for each accepted halfword.
- R6: out_valid rises only when an instruction is complete. Cycles without in_valid between the two halves give no output.
- R7: flush discards a held leading half and any undelivered output, holds in_ready at 0, and makes the next accepted halfword start an instruction at address flush_addr.
- R8: While out_valid=1 and out_ready=0, the output fields stay stable and in_ready is 0.
- R9: The halfword after a leading half is always taken as the second half, even if its own bits [15:11] match a leading pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop partial state and restart at flush_addr |
| flush_addr | input | ADDR_W | Fetch address loaded by flush |
| in_valid | input | 1 | Halfword offered by fetch |
| in_ready | output | 1 | Halfword accepted when high with in_valid |
| in_half | input | 16 | Halfword value |
| out_valid | output | 1 | Complete instruction available |
| out_ready | input | 1 | Consumer takes the instruction |
| out_insn | output | 32 | Instruction, leading half in the upper bits when wide |
| out_wide | output | 1 | 1 for a 32-bit instruction, 0 for 16-bit |
| out_addr | output | ADDR_W | Address of the instruction's first halfword |

## Verification
The bench goes after the length boundary. 0xE7FF is the last 16-bit pattern and 0xE800 the first leading pattern, so a decoder with an off-by-one in the prefix compare would emit a lone leading half or swallow a 16-bit instruction. A stall of several cycles sits between the two halves, which catches a design that emits the leading half early. A second half that itself looks like a leading half checks R9; a design that got this wrong would re-hold it and lose alignment. A flush taken while a leading half is held shows whether a stale half gets joined to the next halfword or the old address survives. Stretches of output backpressure show whether data changes or input is taken while an instruction waits.

// File: rtl/insn_pair_pkg.sv
package insn_pair_pkg;
  localparam int HALF_W = 16;
  localparam int INSN_W = 2 * HALF_W;
  localparam int PFX_HI = HALF_W - 1;
  localparam int PFX_LO = HALF_W - 5;

  // Leading-half prefixes (bits [15:11]) that open a 32-bit instruction
  localparam logic [4:0] PFX_A = 5'b11101;
  localparam logic [4:0] PFX_B = 5'b11110;
  localparam logic [4:0] PFX_C = 5'b11111;

  function automatic logic is_lead(input logic [HALF_W-1:0] h);
    logic [4:0] p;
    p = h[PFX_HI:PFX_LO];
    return (p == PFX_A) || (p == PFX_B) || (p == PFX_C);
  endfunction

  function automatic logic [INSN_W-1:0] join_halves(input logic [HALF_W-1:0] first,
                                                     input logic [HALF_W-1:0] second);
    return {first, second};
  endfunction

  function automatic logic [INSN_W-1:0] widen_narrow(input logic [HALF_W-1:0] h);
    return {{HALF_W{1'b0}}, h};
  endfunction
endpackage

// File: rtl/ip_addr_track.sv
module ip_addr_track #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic [ADDR_W-1:0] restart_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] pc
);
  localparam logic [ADDR_W-1:0] STEP_BYTES = ADDR_W'(2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pc <= RESET_ADDR;
    else if (restart) pc <= restart_addr;
    else if (step)    pc <= pc + STEP_BYTES;
  end

  // R5: one halfword consumed moves the fetch address by two bytes
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (pc - $past(pc)) == STEP_BYTES);

  // R7: restart loads the requested address
  a_r7_restart_addr: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pc == $past(restart_addr));
endmodule

// File: rtl/ip_lead_hold.sv
module ip_lead_hold #(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             take,
  input  logic [insn_pair_pkg::HALF_W-1:0] half,
  input  logic [ADDR_W-1:0]                pc,
  output logic                             pending,
  output logic                             emit,
  output logic [insn_pair_pkg::INSN_W-1:0] emit_insn,
  output logic                             emit_wide,
  output logic [ADDR_W-1:0]                emit_addr
);
  import insn_pair_pkg::*;

  logic [HALF_W-1:0] held_half;
  logic [ADDR_W-1:0] held_addr;
  logic              starts_wide;
  logic              closes_wide;

  assign starts_wide = take && !pending && is_lead(half);
  assign closes_wide = take && pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending   <= 1'b0;
      held_half <= '0;
      held_addr <= '0;
    end else if (clear) begin
      pending   <= 1'b0;
    end else if (starts_wide) begin
      pending   <= 1'b1;
      held_half <= half;
      held_addr <= pc;
    end else if (closes_wide) begin
      pending   <= 1'b0;
    end
  end

  always_comb begin
    emit      = 1'b0;
    emit_insn = widen_narrow(half);
    emit_wide = 1'b0;
    emit_addr = pc;
    if (closes_wide) begin
      emit      = 1'b1;
      emit_insn = join_halves(held_half, half);
      emit_wide = 1'b1;
      emit_addr = held_addr;
    end else if (take && !starts_wide) begin
      emit      = 1'b1;
    end
  end

  // R3: a leading half never completes on its own
  a_r3_lead_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !pending && is_lead(half)) |-> !emit);

  // R9: with a half pending, the next accepted halfword always closes it
  a_r9_second_joins: assert property (@(posedge clk) disable iff (!rst_n)
    (take && pending && !clear) |=> !pending);

  // R4: the second half arrives two bytes after the held one
  a_r4_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    closes_wide |-> (pc - held_addr) == ADDR_W'(2));
endmodule

// File: rtl/ip_out_slot.sv
module ip_out_slot #(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clear,
  input  logic                             load,
  input  logic [insn_pair_pkg::INSN_W-1:0] load_insn,
  input  logic                             load_wide,
  input  logic [ADDR_W-1:0]                load_addr,
  input  logic                             out_ready,
  output logic                             free,
  output logic                             out_valid,
  output logic [insn_pair_pkg::INSN_W-1:0] out_insn,
  output logic                             out_wide,
  output logic [ADDR_W-1:0]                out_addr
);
  import insn_pair_pkg::*;

  assign free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_insn  <= '0;
      out_wide  <= 1'b0;
      out_addr  <= '0;
    end else if (clear) begin
      out_valid <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_insn  <= load_insn;
      out_wide  <= load_wide;
      out_addr  <= load_addr;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a stalled instruction is held unchanged
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !clear) |=>
      (out_valid && $stable(out_insn) && $stable(out_wide) && $stable(out_addr)));

  // R8: nothing is loaded over a stalled instruction
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> free);

  // R6: valid only rises on a completed instruction
  a_r6_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(load));

  // R2: narrow instructions carry a zero upper half
  a_r2_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_wide) |-> out_insn[INSN_W-1:HALF_W] == '0);

  // R4: wide instructions start with a leading prefix
  a_r4_wide_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_wide) |-> is_lead(out_insn[INSN_W-1:HALF_W]));
endmodule

// File: rtl/insn_pairer.sv
module insn_pairer #(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_half,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_insn,
  output logic              out_wide,
  output logic [ADDR_W-1:0] out_addr
);
  import insn_pair_pkg::*;

  logic              slot_free;
  logic              in_fire;
  logic [ADDR_W-1:0] pc;
  logic              pending;
  logic              emit;
  logic [INSN_W-1:0] emit_insn;
  logic              emit_wide;
  logic [ADDR_W-1:0] emit_addr;

  assign in_ready = !flush && slot_free;
  assign in_fire  = in_valid && in_ready;

  ip_addr_track #(.ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart(flush), .restart_addr(flush_addr),
    .step(in_fire), .pc(pc)
  );

  ip_lead_hold #(.ADDR_W(ADDR_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .clear(flush), .take(in_fire), .half(in_half),
    .pc(pc), .pending(pending), .emit(emit), .emit_insn(emit_insn),
    .emit_wide(emit_wide), .emit_addr(emit_addr)
  );

  ip_out_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .clear(flush), .load(emit),
    .load_insn(emit_insn), .load_wide(emit_wide), .load_addr(emit_addr),
    .out_ready(out_ready), .free(slot_free), .out_valid(out_valid),
    .out_insn(out_insn), .out_wide(out_wide), .out_addr(out_addr)
  );

  // R7: flush leaves no partial or pending instruction behind
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!out_valid && !pending));

  // R7: input is refused during flush
  a_r7_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  // R6: a stall with a half held produces nothing
  a_r6_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !in_valid && !out_valid) |=> !out_valid);
endmodule

// File: tb/test_insn_pairer.sv
`timescale 1ns/1ps
module test_insn_pairer;
  localparam int ADDR_W = 32;
  localparam logic [31:0] RST_A = 32'h0000_0000;

  typedef struct {
    logic [31:0] insn;
    logic        wide;
    logic [31:0] addr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] flush_addr = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_half = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_insn;
  logic        out_wide;
  logic [31:0] out_addr;

  int checks = 0;
  int errors = 0;
  int bp_mode = 0;
  int cycles = 0;

  exp_t        q[$];
  logic        m_lead = 1'b0;
  logic [15:0] m_lead_half = '0;
  logic [31:0] m_lead_addr = '0;
  logic [31:0] m_pc = RST_A;

  always #2.5 clk = ~clk;

  insn_pairer #(.ADDR_W(ADDR_W), .RESET_ADDR(RST_A)) i_insn_pairer (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
    .out_wide(out_wide), .out_addr(out_addr)
  );

  function automatic logic lead_pat(input logic [15:0] h);
    int p;
    p = int'(h >> 11);
    return p >= 29;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output stall pattern
  always @(negedge clk) begin
    if (bp_mode == 0)      out_ready <= 1'b1;
    else if (bp_mode == 1) out_ready <= 1'b0;
    else                   out_ready <= (($urandom % 4) != 0);
  end

  // Reference model, sampled half a nanosecond before each rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (flush) begin
        q.delete();
        m_lead = 1'b0;
        m_pc = flush_addr;
        check("R7 in_ready during flush", {31'b0, in_ready}, 32'd0);
      end else begin
        check("R8 in_ready", {31'b0, in_ready}, {31'b0, (!out_valid || out_ready)});
        if (out_valid) begin
          if (q.size() == 0) begin
            check("R6 spurious out_valid", 32'd1, 32'd0);
          end else begin
            check(q[0].wide ? "R4/R9 insn" : "R2 insn", out_insn, q[0].insn);
            check("R4 width flag", {31'b0, out_wide}, {31'b0, q[0].wide});
            check("R5 addr", out_addr, q[0].addr);
            if (out_ready) void'(q.pop_front());
          end
        end
        if (in_valid && in_ready) begin
          exp_t e;
          if (m_lead) begin
            e.insn = {m_lead_half, in_half};
            e.wide = 1'b1;
            e.addr = m_lead_addr;
            q.push_back(e);
            m_lead = 1'b0;
          end else if (lead_pat(in_half)) begin
            m_lead = 1'b1;
            m_lead_half = in_half;
            m_lead_addr = m_pc;
          end else begin
            e.insn = {16'h0000, in_half};
            e.wide = 1'b0;
            e.addr = m_pc;
            q.push_back(e);
          end
          m_pc = m_pc + 32'd2;
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // Called at a falling edge; returns at the falling edge after acceptance
  task automatic send(input logic [15:0] h);
    in_valid = 1'b1;
    in_half = h;
    #2;
    while (!in_ready) #5;
    #3;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    #(5 * n);
  endtask

  task automatic flush_to(input logic [31:0] a);
    in_valid = 1'b0;
    flush = 1'b1;
    flush_addr = a;
    #5;
    flush = 1'b0;
  endtask

  initial begin
    #12.5;
    rst_n = 1'b1;
    #2;
    // R1: reset state
    check("R1 out_valid after reset", {31'b0, out_valid}, 32'd0);
    check("R1 in_ready after reset", {31'b0, in_ready}, 32'd1);
    #0.5;
    // now at a falling edge
    send(16'h200A);             // R1/R2: narrow at RESET_ADDR
    send(16'hE800);             // R3: first leading pattern
    idle(1);
    #2;
    check("R3 no output after lead", {31'b0, out_valid}, 32'd0);
    #3;
    idle(2);                    // R6: stall between halves
    #2;
    check("R6 no output during stall", {31'b0, out_valid}, 32'd0);
    #3;
    send(16'hF000);             // R9: second half with a leading pattern
    send(16'hE7FF);             // R2: last narrow pattern
    send(16'hFFFF);
    send(16'h4770);
    idle(3);
    // R8: backpressure holds the output and refuses input
    bp_mode = 1;
    idle(1);
    send(16'h1234);
    idle(1);
    #2;
    check("R8 out_valid held", {31'b0, out_valid}, 32'd1);
    check("R8 in_ready low", {31'b0, in_ready}, 32'd0);
    #3;
    idle(3);
    bp_mode = 0;
    idle(3);
    // R7: flush with a held leading half
    send(16'hF000);
    flush_to(32'h0000_0100);
    #2;
    check("R7 out_valid after flush", {31'b0, out_valid}, 32'd0);
    #3;
    send(16'h4770);             // must be narrow at 0x100
    idle(1);
    #2;
    check("R7 narrow after flush", out_insn, 32'h0000_4770);
    check("R7 addr after flush", out_addr, 32'h0000_0100);
    #3;
    idle(2);
    // Random phase
    bp_mode = 2;
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r == 0) begin
        flush_to({$urandom} & 32'hFFFF_FFFE);
      end else if (r < 15) begin
        idle(1 + int'($urandom % 3));
      end else if (r < 50) begin
        send({5'(29 + ($urandom % 3)), 11'($urandom)});
      end else begin
        send(16'($urandom));
      end
    end
    bp_mode = 0;
    idle(10);
    check("R5 all expected instructions delivered", q.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule